// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between an 8-bit handheld-console CPU bus and a cartridge that carries more ROM and RAM than the 16-bit address space can reach directly. It decodes each bus access. Writes into the ROM half of the map do not reach ROM. They act as control writes that pick the switchable ROM bank, pick either a RAM bank or a real-time-clock register for the external window, gate RAM and clock access on or off, and arm a clock latch.

For every access the block produces the physical ROM address, the physical RAM address, chip enables, a RAM write strobe, a clock-register write strobe with a 3-bit register index, and a one-cycle latch pulse. It also drives the read data back to the CPU. That data is a mux of ROM data, RAM data, clock-register data or an idle value of 0xFF. The clock counter itself lives outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF with data 0x0A enables the external window and data 0x00 disables it; any other value leaves the enable as it was.
- R2: A write to 0x2000–0x3FFF takes the switchable ROM bank from data bits [6:0]; bit 7 is ignored.
- R3: A requested ROM bank of 0 becomes bank 1, and a request at or above ROM_BANKS becomes bank ROM_BANKS−1.
- R4: A write to 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank and maps RAM into the window 0xA000–0xBFFF.
- R5: A write to 0x4000–0x5FFF with data 0x08–0x0C maps the clock into the window and sets the clock select output to data−8 (0 to 4). Any other data leaves both the mapping and the selections unchanged.
- R6: A write to 0x6000–0x7FFF of 0x01 drives the latch pulse high for exactly the next clock cycle if the previous write to that range was 0x00. Every write to the range is remembered as the new previous value.
- R7: A read of 0x0000–0x3FFF drives the ROM address equal to the CPU address (bank 0) and returns ROM data.
- R8: A read of 0x4000–0x7FFF drives the ROM address bank×0x4000 + (address−0x4000) and returns ROM data.
- R9: With RAM mapped and enabled, a window access drives the RAM address bank×0x2000 + (address−0xA000), and a write raises the RAM write strobe.
- R10: When the window is disabled, or the RAM address is at or above RAM_BYTES, a window read returns 0xFF and a window write raises no RAM write strobe.
- R11: With the clock mapped and enabled, a window read returns the clock data input, and a window write raises the clock write strobe and no RAM write strobe.
- R12: After reset the ROM bank is 1, the RAM bank is 0, the window is disabled, the clock select is 0 and the latch history is 0x00.
- R13: A read of 0x8000–0x9FFF or 0xC000–0xFFFF returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write, one cycle per write |
| cpu_rd | input | 1 | CPU read |
| cpu_rdata | output | 8 | Read data to CPU |
| rom_addr | output | ROM_AW | Physical ROM address |
| rom_ce | output | 1 | ROM chip enable |
| rom_rdata | input | 8 | ROM data |
| ram_addr | output | 15 | Physical RAM address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write strobe (data is cpu_wdata) |
| ram_rdata | input | 8 | RAM data |
| clk_sel | output | 3 | Selected clock register index |
| clk_we | output | 1 | Clock register write strobe |
| clk_rdata | input | 8 | Data of the selected clock register |
| latch_pulse | output | 1 | One-cycle clock latch pulse |

## Verification
The bench aims at the bank edges. Bank 0 must read as bank 1, a request past the last bank must stop at the last bank, and bit 7 of the bank write must be dropped. A design that got these wrong would fetch from the fixed bank or from a nonexistent address. It uses a RAM model that aliases the unpopulated banks onto the real ones. A write that slips past the installed-size or disable gate then shows up as corrupted data in a live bank. It walks the latch history through 0→1, 1→1, 0→2→1 and the reset value, so a design that only looks at the current data, or forgets the intermediate write, pulses at the wrong time. Out-of-range clock selects and other enable values are written between reads to show that they change nothing.

// File: rtl/cart_pkg.sv
package cart_pkg;
  // Region code is address bits [15:13]; the decode depends on this order.
  typedef enum logic [2:0] {
    RG_ENABLE  = 3'd0,
    RG_ROMBANK = 3'd1,
    RG_WINSEL  = 3'd2,
    RG_LATCH   = 3'd3,
    RG_VIDEO   = 3'd4,
    RG_WINDOW  = 3'd5,
    RG_HIGH0   = 3'd6,
    RG_HIGH1   = 3'd7
  } region_t;

  localparam logic [7:0] ENABLE_ON  = 8'h0A;
  localparam logic [7:0] ENABLE_OFF = 8'h00;
  localparam logic [7:0] CLKSEL_LO  = 8'h08;
  localparam logic [7:0] CLKSEL_HI  = 8'h0C;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/cart_decode.sv
module cart_decode
  import cart_pkg::*;
(
  input  logic [2:0] addr_hi,
  input  logic       cpu_wr,
  output region_t    region,
  output logic       wr_enable,
  output logic       wr_rombank,
  output logic       wr_winsel,
  output logic       wr_latch
);
  always_comb begin
    region     = region_t'(addr_hi);
    wr_enable  = cpu_wr && (region == RG_ENABLE);
    wr_rombank = cpu_wr && (region == RG_ROMBANK);
    wr_winsel  = cpu_wr && (region == RG_WINSEL);
    wr_latch   = cpu_wr && (region == RG_LATCH);
  end
endmodule

// File: rtl/cart_regs.sv
module cart_regs
  import cart_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int BANK_W   = $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable,
  input  logic              wr_rombank,
  input  logic              wr_winsel,
  input  logic              wr_latch,
  input  logic [7:0]        wdata,
  output logic              win_en,
  output logic [BANK_W-1:0] rom_bank,
  output logic [1:0]        ram_bank,
  output logic              clk_map,
  output logic [2:0]        clk_sel,
  output logic              latch_pulse
);
  logic              en_ce, en_d;
  logic              bank_ce;
  logic [BANK_W-1:0] bank_d;
  logic              sel_ram_ok, sel_clk_ok;
  logic              ram_bank_ce, clk_sel_ce, map_ce;
  logic [7:0]        clk_off;
  logic [7:0]        hist_q;
  logic              pulse_d;

  always_comb begin
    en_ce = wr_enable && (wdata == ENABLE_ON || wdata == ENABLE_OFF);
    en_d  = (wdata == ENABLE_ON);

    bank_ce = wr_rombank;
    if (wdata[6:0] == 7'd0)
      bank_d = BANK_W'(1);
    else if (int'(wdata[6:0]) >= ROM_BANKS)
      bank_d = BANK_W'(ROM_BANKS - 1);
    else
      bank_d = BANK_W'(wdata[6:0]);

    sel_ram_ok  = (wdata <= 8'h03);
    sel_clk_ok  = (wdata >= CLKSEL_LO) && (wdata <= CLKSEL_HI);
    ram_bank_ce = wr_winsel && sel_ram_ok;
    clk_sel_ce  = wr_winsel && sel_clk_ok;
    map_ce      = ram_bank_ce || clk_sel_ce;
    clk_off     = wdata - CLKSEL_LO;

    pulse_d = wr_latch && (hist_q == 8'h00) && (wdata == 8'h01);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en      <= 1'b0;
      rom_bank    <= BANK_W'(1);
      ram_bank    <= 2'd0;
      clk_map     <= 1'b0;
      clk_sel     <= 3'd0;
      hist_q      <= 8'h00;
      latch_pulse <= 1'b0;
    end else begin
      if (en_ce)       win_en   <= en_d;
      if (bank_ce)     rom_bank <= bank_d;
      if (ram_bank_ce) ram_bank <= wdata[1:0];
      if (clk_sel_ce)  clk_sel  <= clk_off[2:0];
      if (map_ce)      clk_map  <= sel_clk_ok;
      if (wr_latch)    hist_q   <= wdata;
      latch_pulse <= pulse_d;
    end
  end

  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != '0);
  p_bank_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rom_bank) < ROM_BANKS);
  p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel <= 3'd4);
  p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && wdata != ENABLE_ON && wdata != ENABLE_OFF) |=> $stable(win_en));
  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> !latch_pulse);
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_latch && wdata != 8'h01) |=> !latch_pulse);
endmodule

// File: rtl/cart_map.sv
module cart_map
  import cart_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BYTES = 16384,
  localparam int BANK_W   = $clog2(ROM_BANKS),
  localparam int ROM_AW   = BANK_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  region_t           region,
  input  logic              win_en,
  input  logic [BANK_W-1:0] rom_bank,
  input  logic [1:0]        ram_bank,
  input  logic              clk_map,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        clk_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce,
  output logic [14:0]       ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic              clk_we,
  output logic [7:0]        cpu_rdata
);
  logic              in_rom, in_win, ram_fits, ram_ok, clk_ok;
  logic [BANK_W-1:0] bank_eff;

  always_comb begin
    in_rom   = !cpu_addr[15];
    in_win   = (region == RG_WINDOW);
    bank_eff = cpu_addr[14] ? rom_bank : '0;
    rom_addr = {bank_eff, cpu_addr[13:0]};
    rom_ce   = cpu_rd && in_rom;

    ram_addr = {ram_bank, cpu_addr[12:0]};
    ram_fits = 32'(ram_addr) < RAM_BYTES;
    ram_ok   = in_win && win_en && !clk_map && ram_fits;
    clk_ok   = in_win && win_en && clk_map;
    ram_ce   = ram_ok && (cpu_rd || cpu_wr);
    ram_we   = ram_ok && cpu_wr;
    clk_we   = clk_ok && cpu_wr;

    if (in_rom)      cpu_rdata = rom_rdata;
    else if (clk_ok) cpu_rdata = clk_rdata;
    else if (ram_ok) cpu_rdata = ram_rdata;
    else             cpu_rdata = IDLE_BYTE;
  end

  p_ram_we_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (win_en && !clk_map));
  p_win_off_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !win_en) |-> (cpu_rdata == IDLE_BYTE && !ram_we && !clk_we));
  p_fixed_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:14] == '0));
  p_clk_no_ram_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_we |-> !ram_ce);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BYTES = 16384,
  localparam int BANK_W   = $clog2(ROM_BANKS),
  localparam int ROM_AW   = BANK_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce,
  input  logic [7:0]        rom_rdata,
  output logic [14:0]       ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata,
  output logic [2:0]        clk_sel,
  output logic              clk_we,
  input  logic [7:0]        clk_rdata,
  output logic              latch_pulse
);
  logic [1:0]        rst_sync;
  logic              rst_n_i;
  region_t           region;
  logic              wr_enable, wr_rombank, wr_winsel, wr_latch;
  logic              win_en, clk_map;
  logic [BANK_W-1:0] rom_bank;
  logic [1:0]        ram_bank;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  cart_decode u_decode (
    .addr_hi    (cpu_addr[15:13]),
    .cpu_wr     (cpu_wr),
    .region     (region),
    .wr_enable  (wr_enable),
    .wr_rombank (wr_rombank),
    .wr_winsel  (wr_winsel),
    .wr_latch   (wr_latch)
  );

  cart_regs #(.ROM_BANKS(ROM_BANKS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .wr_enable   (wr_enable),
    .wr_rombank  (wr_rombank),
    .wr_winsel   (wr_winsel),
    .wr_latch    (wr_latch),
    .wdata       (cpu_wdata),
    .win_en      (win_en),
    .rom_bank    (rom_bank),
    .ram_bank    (ram_bank),
    .clk_map     (clk_map),
    .clk_sel     (clk_sel),
    .latch_pulse (latch_pulse)
  );

  cart_map #(.ROM_BANKS(ROM_BANKS), .RAM_BYTES(RAM_BYTES)) u_map (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .region    (region),
    .win_en    (win_en),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .clk_map   (clk_map),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .clk_rdata (clk_rdata),
    .rom_addr  (rom_addr),
    .rom_ce    (rom_ce),
    .ram_addr  (ram_addr),
    .ram_ce    (ram_ce),
    .ram_we    (ram_we),
    .clk_we    (clk_we),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: tb/cart_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cart_bank_ctrl_bench;
  localparam int ROM_AW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata, rom_rdata, ram_rdata, clk_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic        rom_ce, ram_ce, ram_we, clk_we, latch_pulse;
  logic [14:0] ram_addr;
  logic [2:0]  clk_sel;

  int checks = 0, fails = 0, cycles = 0;
  logic last_pulse;

  always #4 clk = ~clk; // 125 MHz

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_ce(rom_ce), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .clk_sel(clk_sel), .clk_we(clk_we), .clk_rdata(clk_rdata),
    .latch_pulse(latch_pulse)
  );

  // ROM model: bit 7 = address bit 0, bits 5:0 = bank number.
  assign rom_rdata = {rom_addr[0], 1'b0, rom_addr[19:14]};
  // Clock model: register index in the low bits.
  assign clk_rdata = 8'hC0 | {5'd0, clk_sel};
  // RAM model: 8 bytes indexed by {addr bit 13, addr bits 1:0}; banks 2,3 alias 0,1.
  logic [7:0] ram_mem [8];
  assign ram_rdata = ram_mem[{ram_addr[13], ram_addr[1:0]}];
  always @(posedge clk) if (ram_we) ram_mem[{ram_addr[13], ram_addr[1:0]}] <= cpu_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
    last_pulse = latch_pulse;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0002, 8'h00, 8'h00, 8'd7 },  // R7 fixed bank
    '{1'b0, 16'h4000, 8'h00, 8'h01, 8'd12},  // R12 bank 1 after reset
    '{1'b1, 16'h2000, 8'h05, 8'h00, 8'd2 },
    '{1'b0, 16'h7FFE, 8'h00, 8'h05, 8'd8 },  // R8
    '{1'b1, 16'h2100, 8'h00, 8'h00, 8'd3 },
    '{1'b0, 16'h4002, 8'h00, 8'h01, 8'd3 },  // R3 zero -> 1
    '{1'b1, 16'h3FFF, 8'h7F, 8'h00, 8'd3 },
    '{1'b0, 16'h4000, 8'h00, 8'h3F, 8'd3 },  // R3 clamp
    '{1'b1, 16'h2000, 8'h85, 8'h00, 8'd2 },
    '{1'b0, 16'h4000, 8'h00, 8'h05, 8'd2 },  // R2 bit 7 dropped
    '{1'b0, 16'h4001, 8'h00, 8'h85, 8'd8 },  // R8 offset
    '{1'b0, 16'hA000, 8'h00, 8'hFF, 8'd10},  // R10 disabled
    '{1'b1, 16'hA000, 8'h55, 8'h00, 8'd10},
    '{1'b1, 16'h0000, 8'h0A, 8'h00, 8'd1 },
    '{1'b0, 16'hA000, 8'h00, 8'h00, 8'd1 },  // R1 enabled, disabled write lost
    '{1'b1, 16'hA000, 8'h55, 8'h00, 8'd9 },
    '{1'b0, 16'hA000, 8'h00, 8'h55, 8'd9 },  // R9
    '{1'b1, 16'h4000, 8'h01, 8'h00, 8'd4 },
    '{1'b0, 16'hA000, 8'h00, 8'h00, 8'd4 },  // R4 bank 1 separate
    '{1'b1, 16'hA001, 8'h66, 8'h00, 8'd9 },
    '{1'b1, 16'h4000, 8'h02, 8'h00, 8'd10},
    '{1'b0, 16'hA001, 8'h00, 8'hFF, 8'd10},  // R10 beyond RAM
    '{1'b1, 16'hA001, 8'h77, 8'h00, 8'd10},
    '{1'b1, 16'h4000, 8'h00, 8'h00, 8'd4 },
    '{1'b0, 16'hA001, 8'h00, 8'h00, 8'd10},  // R10 alias untouched
    '{1'b1, 16'h4000, 8'h01, 8'h00, 8'd4 },
    '{1'b0, 16'hA001, 8'h00, 8'h66, 8'd4 },  // R4
    '{1'b1, 16'h4000, 8'h0A, 8'h00, 8'd5 },
    '{1'b0, 16'hB000, 8'h00, 8'hC2, 8'd11},  // R11 clock read
    '{1'b1, 16'h4000, 8'h0D, 8'h00, 8'd5 },
    '{1'b0, 16'hA000, 8'h00, 8'hC2, 8'd5 },  // R5 0x0D ignored
    '{1'b1, 16'h4000, 8'h07, 8'h00, 8'd5 },
    '{1'b0, 16'hA000, 8'h00, 8'hC2, 8'd5 },  // R5 0x07 ignored
    '{1'b1, 16'h4000, 8'h0C, 8'h00, 8'd5 },
    '{1'b0, 16'hA000, 8'h00, 8'hC4, 8'd5 },  // R5 top register
    '{1'b1, 16'h0000, 8'h33, 8'h00, 8'd1 },
    '{1'b0, 16'hA000, 8'h00, 8'hC4, 8'd1 },  // R1 other value holds
    '{1'b1, 16'h1FFF, 8'h00, 8'h00, 8'd1 },
    '{1'b0, 16'hA000, 8'h00, 8'hFF, 8'd1 },  // R1 disable
    '{1'b1, 16'h0000, 8'h0A, 8'h00, 8'd1 },
    '{1'b1, 16'h4000, 8'h00, 8'h00, 8'd4 },
    '{1'b0, 16'hA000, 8'h00, 8'h55, 8'd4 },  // R4 back to RAM
    '{1'b0, 16'h8000, 8'h00, 8'hFF, 8'd13},  // R13
    '{1'b0, 16'hC000, 8'h00, 8'hFF, 8'd13},  // R13
    '{1'b1, 16'h4000, 8'h03, 8'h00, 8'd10},
    '{1'b0, 16'hA000, 8'h00, 8'hFF, 8'd10}   // R10 bank 3 absent
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ram_mem[i] = 8'h00;
    do_reset();

    // R12 reset state at the ports
    do_read(16'h4000);
    check(rom_addr == 20'h04000, "R12 rom bank", int'(rom_addr), 'h04000);
    check(clk_sel == 3'd0, "R12 clk_sel", int'(clk_sel), 0);
    check(latch_pulse == 1'b0, "R12 latch_pulse", int'(latch_pulse), 0);
    do_read(16'hA000);
    check(cpu_rdata == 8'hFF, "R12 window disabled", int'(cpu_rdata), 'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr);
        check(cpu_rdata == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i),
              int'(cpu_rdata), int'(VECS[i].exp));
      end
    end

    // R7 and R8 address forms
    do_write(16'h2000, 8'h05);
    do_read(16'h3ABC);
    check(rom_addr == 20'h03ABC && rom_ce, "R7 rom_addr", int'(rom_addr), 'h03ABC);
    do_read(16'h5ABC);
    check(rom_addr == 20'h15ABC && rom_ce, "R8 rom_addr", int'(rom_addr), 'h15ABC);

    // R9 RAM address and strobe
    do_write(16'h0000, 8'h0A);
    do_write(16'h4000, 8'h01);
    @(negedge clk);
    cpu_addr = 16'hA123; cpu_wdata = 8'h12; cpu_wr = 1'b1; #1;
    check(ram_addr == 15'h2123 && ram_we && !clk_we, "R9 ram_addr/ram_we", int'(ram_addr), 'h2123);
    @(negedge clk); cpu_wr = 1'b0;

    // R11 clock write strobe and index
    do_write(16'h4000, 8'h09);
    @(negedge clk);
    cpu_addr = 16'hA123; cpu_wdata = 8'h34; cpu_wr = 1'b1; #1;
    check(clk_we && !ram_we && clk_sel == 3'd1, "R11 clk_we/clk_sel",
          int'({clk_we, ram_we, clk_sel}), 'b10001);
    @(negedge clk); cpu_wr = 1'b0;

    // R6 latch sequences; R12 history is 0x00 after reset
    do_reset();
    do_write(16'h6000, 8'h01);
    check(last_pulse == 1'b1, "R6 first 0x01 after reset", int'(last_pulse), 1);
    @(negedge clk);
    check(latch_pulse == 1'b0, "R6 pulse one cycle", int'(latch_pulse), 0);
    do_write(16'h7FFF, 8'h01);
    check(last_pulse == 1'b0, "R6 1 then 1", int'(last_pulse), 0);
    do_write(16'h6000, 8'h00);
    check(last_pulse == 1'b0, "R6 write of 0", int'(last_pulse), 0);
    do_write(16'h6000, 8'h01);
    check(last_pulse == 1'b1, "R6 0 then 1", int'(last_pulse), 1);
    do_write(16'h6000, 8'h00);
    do_write(16'h6000, 8'h02);
    do_write(16'h6000, 8'h01);
    check(last_pulse == 1'b0, "R6 0,2,1", int'(last_pulse), 0);

    // R12 reset restores bank after a change
    do_write(16'h2000, 8'h07);
    do_reset();
    do_read(16'h4000);
    check(cpu_rdata == 8'h01, "R12 bank after second reset", int'(cpu_rdata), 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule